// File: doc/BRIEF.md
# Modulo Alarm Timer

A memory-mapped 16-bit up-counter intended as a wake-up alarm. Software programs a start value and a modulo (terminal) value, selects the tick source and a power-of-two prescaler, and enables counting. The counter climbs from the start value to the modulo value. On the next counted tick it reloads the start value instead of incrementing. That reload sets an overflow flag, and the flag drives a level interrupt when the interrupt enable is set. An alarm of N counted ticks is therefore programmed as modulo = N-1 with a start value of 0.

The registers sit on a simple single-cycle 32-bit read/write bus. Reads are combinational from the selected register, and writes take effect at the clock edge on which `bus_sel` and `bus_wr` are high. The overflow flag is cleared by a handshake: a read of the control register that sees the flag set, and then a write of 0 to the flag bit. A small three-state machine tracks this handshake.

The state machine has these states:
- `FLAG_IDLE`: no flag.
- `FLAG_PENDING`: flag set, not yet observed.
- `FLAG_ARMED`: flag set and observed by a read.

It has these transitions:
- `set` (IDLE to PENDING) on a reload.
- `observe` (PENDING to ARMED) on a control read.
- `clear` (ARMED to IDLE) on a flag-zero control write.
- `re-raise` (ARMED to PENDING) when a clear write and a reload fall in the same cycle.

A build-time option byte-swaps every bus word, for hosts that use big-endian ordering.

Top module: `modulo_alarm_timer`

## Requirements
- R1: After reset the control register reads 0, the count and start registers read 0, the modulo register reads 0x0000FFFF, and `irq` is low.
- R2: The register offsets are control 0x00, count 0x04, modulo 0x08 and start value 0x4C. The control register has these fields: bits 2:0 prescaler code, bits 4:3 source select, bit 6 interrupt enable, bit 7 overflow flag, and bit 5 reads 0. The count, modulo and start registers return their value in bits 15:0, with the upper bits reading 0.
- R3: Only source-select code 2 lets the counter advance, and it then counts the `tick_in` input (one tick per clock cycle with `tick_in` high). Codes 0, 1 and 3 hold the count.
- R4: With prescaler code p, the count advances once per 2^p ticks. Any write to the control register restarts the prescaler phase, so the first advance comes on the 2^p-th tick after that write.
- R5: While the count differs from the modulo value, a counted tick adds one. When the count equals the modulo value, the next counted tick loads the start value.
- R6: The overflow flag sets in the cycle in which the count reloads from the modulo value to the start value.
- R7: A write of any data to the count register loads the start value. This takes priority over a counted tick in the same cycle.
- R8: Writing 1 to the flag bit never changes the flag.
- R9: A control write with the flag bit at 0 clears the flag only if an earlier control read returned the flag set. Without such a read, the flag stays set.
- R10: If a reload happens in the same cycle as a clearing write, the flag stays set, and a new read is needed before the next clear.
- R11: `irq` is high exactly while the flag and the interrupt enable are both set. It stays high until the flag is cleared.
- R12: With `BYTE_SWAP` = 1, bus write data and read data are byte-reversed relative to the register layout of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational |
| tick_in | input | 1 | Fixed-frequency tick qualifier |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions check, on every cycle, the local step rules:
- The reload loads the start value and raises the flag (R5, R6).
- A count write loads the start value (R7).
- Counting stays frozen for every source code other than 2 (R3).
- Writing 1 to the flag bit never drops it (R8).
- The interrupt holds without a control write (R11).

Other properties depend on sequences of accesses, so only the bench scenarios can show them:
- The read-before-clear handshake (R9) and the priority of a reload over a same-cycle clear (R10).
- The exact prescaler periods at codes 2 and 7 (R4).
- The byte-swapped view of the registers (R12).

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;

    // Register offsets on the bus (byte addresses)
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h04;
    localparam logic [7:0] OFS_MODULO = 8'h08;
    localparam logic [7:0] OFS_START  = 8'h4C;

    // Source select codes
    localparam logic [1:0] SRC_OFF  = 2'd0;
    localparam logic [1:0] SRC_TICK = 2'd2;

    // Overflow flag handshake states
    typedef enum logic [1:0] {
        FLAG_IDLE    = 2'd0,
        FLAG_PENDING = 2'd1,
        FLAG_ARMED   = 2'd2
    } flag_state_e;

endpackage

// File: rtl/alarm_bus_port.sv
module alarm_bus_port #(
    parameter int unsigned DATA_W = 32,
    parameter bit          SWAP   = 1'b0
) (
    input  logic [DATA_W-1:0] wdata_bus,
    input  logic [DATA_W-1:0] rdata_reg,
    output logic [DATA_W-1:0] wdata_reg,
    output logic [DATA_W-1:0] rdata_bus
);

    localparam int unsigned BYTES = DATA_W / 8;

    generate
        if (SWAP) begin : g_swap
            for (genvar b = 0; b < BYTES; b++) begin : g_byte
                assign wdata_reg[8*b +: 8] = wdata_bus[8*(BYTES-1-b) +: 8];
                assign rdata_bus[8*b +: 8] = rdata_reg[8*(BYTES-1-b) +: 8];
            end
        end else begin : g_native
            assign wdata_reg = wdata_bus;
            assign rdata_bus = rdata_reg;
        end
    endgenerate

endmodule

// File: rtl/alarm_prescaler.sv
module alarm_prescaler #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            restart,
    input  logic            tick_in,
    input  logic [PS_W-1:0] ps_code,
    output logic            count_tick
);

    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] mask;

    // mask has ps_code low ones: terminal phase is 2^p - 1
    assign mask       = ~({DIV_W{1'b1}} << ps_code);
    assign count_tick = enable && tick_in && ((phase & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!enable || restart) begin
            phase <= '0;
        end else if (tick_in) begin
            if (count_tick) begin
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_tick,
    input  logic             load,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] modulo_val,
    output logic [CNT_W-1:0] count_val,
    output logic             wrap
);

    assign wrap = count_tick && !load && (count_val == modulo_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_val <= '0;
        end else if (load || wrap) begin
            count_val <= start_val;
        end else if (count_tick) begin
            count_val <= count_val + 1'b1;
        end
    end

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ctrl_read,
    input  logic ctrl_write,
    input  logic wr_flag_bit,
    output logic flag
);

    flag_state_e state, state_nx;
    logic        clear_req;

    assign clear_req = ctrl_write && !wr_flag_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLAG_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE: begin
                if (wrap) state_nx = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                if (ctrl_read) state_nx = FLAG_ARMED;
            end
            FLAG_ARMED: begin
                if (clear_req && wrap)  state_nx = FLAG_PENDING;
                else if (clear_req)     state_nx = FLAG_IDLE;
            end
            default: state_nx = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state != FLAG_IDLE);
    end

endmodule

// File: rtl/modulo_alarm_timer.sv
module modulo_alarm_timer
    import alarm_timer_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PS_W      = 3,
    parameter bit          BYTE_SWAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_in,
    output logic              irq
);

    localparam int unsigned SRC_LO   = PS_W;
    localparam int unsigned IE_BIT   = PS_W + 3;
    localparam int unsigned FLAG_BIT = PS_W + 4;
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_MODULO = ADDR_W'(OFS_MODULO);
    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(OFS_START);

    logic [DATA_W-1:0] wdata_n;
    logic [DATA_W-1:0] rdata_n;
    logic              ctrl_wr, ctrl_rd, count_wr, modulo_wr, start_wr;
    logic [PS_W-1:0]   ctrl_ps;
    logic [1:0]        ctrl_src;
    logic              ctrl_ie;
    logic [CNT_W-1:0]  modulo_val, start_val, count_val;
    logic              count_tick, wrap, flag;
    logic              unused_wbits;

    alarm_bus_port #(.DATA_W(DATA_W), .SWAP(BYTE_SWAP)) u_port (
        .wdata_bus (bus_wdata),
        .rdata_reg (rdata_n),
        .wdata_reg (wdata_n),
        .rdata_bus (bus_rdata)
    );

    assign unused_wbits = ^wdata_n[DATA_W-1:CNT_W];

    // Address decode
    assign ctrl_wr   = bus_sel &&  bus_wr && (bus_addr == A_CTRL);
    assign ctrl_rd   = bus_sel && !bus_wr && (bus_addr == A_CTRL);
    assign count_wr  = bus_sel &&  bus_wr && (bus_addr == A_COUNT);
    assign modulo_wr = bus_sel &&  bus_wr && (bus_addr == A_MODULO);
    assign start_wr  = bus_sel &&  bus_wr && (bus_addr == A_START);

    // Control and value registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_ps    <= '0;
            ctrl_src   <= SRC_OFF;
            ctrl_ie    <= 1'b0;
            modulo_val <= '1;
            start_val  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_ps  <= wdata_n[PS_W-1:0];
                ctrl_src <= wdata_n[SRC_LO +: 2];
                ctrl_ie  <= wdata_n[IE_BIT];
            end
            if (modulo_wr) modulo_val <= wdata_n[CNT_W-1:0];
            if (start_wr)  start_val  <= wdata_n[CNT_W-1:0];
        end
    end

    alarm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctrl_src == SRC_TICK),
        .restart    (ctrl_wr),
        .tick_in    (tick_in),
        .ps_code    (ctrl_ps),
        .count_tick (count_tick)
    );

    alarm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_tick (count_tick),
        .load       (count_wr),
        .start_val  (start_val),
        .modulo_val (modulo_val),
        .count_val  (count_val),
        .wrap       (wrap)
    );

    alarm_flag_fsm u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .ctrl_read   (ctrl_rd),
        .ctrl_write  (ctrl_wr),
        .wr_flag_bit (wdata_n[FLAG_BIT]),
        .flag        (flag)
    );

    // Read mux
    always_comb begin
        rdata_n = '0;
        case (bus_addr)
            A_CTRL: begin
                rdata_n[PS_W-1:0]     = ctrl_ps;
                rdata_n[SRC_LO +: 2]  = ctrl_src;
                rdata_n[IE_BIT]       = ctrl_ie;
                rdata_n[FLAG_BIT]     = flag;
            end
            A_COUNT:  rdata_n[CNT_W-1:0] = count_val;
            A_MODULO: rdata_n[CNT_W-1:0] = modulo_val;
            A_START:  rdata_n[CNT_W-1:0] = start_val;
            default:  rdata_n = '0;
        endcase
    end

    assign irq = flag && ctrl_ie;

endmodule

// File: rtl/alarm_timer_checker.sv
module alarm_timer_checker #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              count_tick,
    input logic              count_wr,
    input logic              ctrl_wr,
    input logic [DATA_W-1:0] wdata_n,
    input logic [1:0]        ctrl_src,
    input logic [CNT_W-1:0]  count_val,
    input logic [CNT_W-1:0]  modulo_val,
    input logic [CNT_W-1:0]  start_val,
    input logic              flag,
    input logic              irq
);

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && !count_wr && count_val == modulo_val) |=> (count_val == $past(start_val)));

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (count_tick && !count_wr && count_val == modulo_val) |=> flag);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_src != 2'd2 && !count_wr) |=> $stable(count_val));

    a_r7_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        count_wr |=> (count_val == $past(start_val)));

    a_r8_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ctrl_wr && wdata_n[7]) |=> flag);

    a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_wr) |=> irq);

endmodule

bind modulo_alarm_timer alarm_timer_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_tick (count_tick),
    .count_wr   (count_wr),
    .ctrl_wr    (ctrl_wr),
    .wdata_n    (wdata_n),
    .ctrl_src   (ctrl_src),
    .count_val  (count_val),
    .modulo_val (modulo_val),
    .start_val  (start_val),
    .flag       (flag),
    .irq        (irq)
);

// File: tb/test_modulo_alarm_timer.sv
module test_modulo_alarm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0, wr = 1'b0, tick_in = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        irq_a, irq_b;

    int n_checks = 0;
    int n_errors = 0;
    logic mon_req = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          unit_q[$];

    always #2 clk = ~clk;

    modulo_alarm_timer i_modulo_alarm_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .tick_in(tick_in), .irq(irq_a));

    modulo_alarm_timer #(.BYTE_SWAP(1'b1)) i_modulo_alarm_timer_swap (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .tick_in(tick_in), .irq(irq_b));

    // Monitor: pops expected items and compares with the design output
    always @(negedge clk) begin
        #1;
        if (mon_req && exp_q.size() > 0) begin
            logic [31:0] act, expv;
            string       tg;
            int          u;
            expv = exp_q.pop_front();
            tg   = tag_q.pop_front();
            u    = unit_q.pop_front();
            act  = (u == 0) ? rdata_a : (u == 1) ? rdata_b : {31'b0, irq_a};
            n_checks++;
            if (act !== expv) begin
                n_errors++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", tg, act, expv);
            end
        end
    end

    task automatic bus_read(input int unit, input logic [7:0] a,
                            input logic [31:0] expv, input string tg);
        @(negedge clk);
        sel_a = (unit == 0); sel_b = (unit == 1); wr = 1'b0; addr = a;
        exp_q.push_back(expv); tag_q.push_back(tg); unit_q.push_back(unit);
        mon_req = 1'b1;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; mon_req = 1'b0;
    endtask

    task automatic expect_irq(input logic expv, input string tg);
        @(negedge clk);
        exp_q.push_back({31'b0, expv}); tag_q.push_back(tg); unit_q.push_back(2);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
    endtask

    task automatic bus_write(input int unit, input logic [7:0] a,
                             input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        sel_a = (unit == 0); sel_b = (unit == 1); wr = 1'b1; addr = a; wdata = d;
        tick_in = with_tick;
        @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; wr = 1'b0; tick_in = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 layout of value registers
        bus_read(0, 8'h00, 32'h0000_0000, "R1 ctrl after reset");
        bus_read(0, 8'h04, 32'h0000_0000, "R1 count after reset");
        bus_read(0, 8'h08, 32'h0000_FFFF, "R1 R2 modulo after reset");
        bus_read(0, 8'h4C, 32'h0000_0000, "R1 start after reset");
        expect_irq(1'b0, "R1 irq after reset");

        // R7 count write loads start value, data ignored
        bus_write(0, 8'h4C, 32'h0000_0005, 1'b0);
        bus_write(0, 8'h08, 32'hABCD_0009, 1'b0);
        bus_read(0, 8'h08, 32'h0000_0009, "R2 modulo upper bits read zero");
        bus_write(0, 8'h04, 32'h0000_1234, 1'b0);
        bus_read(0, 8'h04, 32'h0000_0005, "R7 count write loads start");

        // R3 codes 0, 1, 3 hold the count
        run_ticks(10);
        bus_read(0, 8'h04, 32'h0000_0005, "R3 source 0 holds");
        bus_write(0, 8'h00, 32'h0000_0008, 1'b0);
        run_ticks(4);
        bus_read(0, 8'h04, 32'h0000_0005, "R3 source 1 holds");
        bus_write(0, 8'h00, 32'h0000_0018, 1'b0);
        run_ticks(4);
        bus_read(0, 8'h04, 32'h0000_0005, "R3 source 3 holds");

        // R3/R5 counting with source 2, prescaler 0
        bus_write(0, 8'h00, 32'h0000_0010, 1'b0);
        run_ticks(3);
        bus_read(0, 8'h04, 32'h0000_0008, "R3 source 2 counts");
        bus_read(0, 8'h00, 32'h0000_0010, "R2 ctrl readback");
        run_ticks(1);
        bus_read(0, 8'h04, 32'h0000_0009, "R5 reaches modulo");
        bus_read(0, 8'h00, 32'h0000_0010, "R6 no flag at modulo");
        run_ticks(1);
        bus_read(0, 8'h04, 32'h0000_0005, "R5 reload to start");
        bus_read(0, 8'h00, 32'h0000_0090, "R6 flag set on reload");
        expect_irq(1'b0, "R11 irq masked by enable");

        // R8 write 1 keeps flag, R11 irq follows enable
        bus_write(0, 8'h00, 32'h0000_00D0, 1'b0);
        bus_read(0, 8'h00, 32'h0000_00D0, "R8 write one keeps flag");
        expect_irq(1'b1, "R11 irq with enable");
        bus_write(0, 8'h00, 32'h0000_0050, 1'b0);
        bus_read(0, 8'h00, 32'h0000_0050, "R9 clear after read");
        expect_irq(1'b0, "R11 irq drops on clear");

        // R9 clear without a prior read has no effect
        run_ticks(5);
        expect_irq(1'b1, "R11 irq on overflow");
        bus_write(0, 8'h00, 32'h0000_0050, 1'b0);
        expect_irq(1'b1, "R9 blind clear ignored");
        bus_read(0, 8'h00, 32'h0000_00D0, "R9 flag still set");
        bus_write(0, 8'h00, 32'h0000_0050, 1'b0);
        expect_irq(1'b0, "R9 clear after read");

        // R10 reload in same cycle as clear keeps flag
        run_ticks(5);
        bus_read(0, 8'h00, 32'h0000_00D0, "R10 flag set before race");
        run_ticks(4);
        bus_read(0, 8'h04, 32'h0000_0009, "R10 count at modulo");
        bus_write(0, 8'h00, 32'h0000_0050, 1'b1);
        bus_read(0, 8'h00, 32'h0000_00D0, "R10 reload beats clear");
        bus_read(0, 8'h04, 32'h0000_0005, "R5 reload during clear");
        bus_write(0, 8'h00, 32'h0000_0050, 1'b0);
        expect_irq(1'b0, "R10 later clear works");

        // R7 priority of count write over tick
        run_ticks(2);
        bus_read(0, 8'h04, 32'h0000_0007, "R5 count advances");
        bus_write(0, 8'h04, 32'hFFFF_FFFF, 1'b1);
        bus_read(0, 8'h04, 32'h0000_0005, "R7 write beats tick");

        // R4 prescaler code 2 and code 7
        bus_write(0, 8'h00, 32'h0000_0012, 1'b0);
        run_ticks(3);
        bus_read(0, 8'h04, 32'h0000_0005, "R4 code 2 before 4 ticks");
        run_ticks(1);
        bus_read(0, 8'h04, 32'h0000_0006, "R4 code 2 at 4 ticks");
        run_ticks(4);
        bus_read(0, 8'h04, 32'h0000_0007, "R4 code 2 second period");
        bus_write(0, 8'h00, 32'h0000_0017, 1'b0);
        run_ticks(127);
        bus_read(0, 8'h04, 32'h0000_0007, "R4 code 7 before 128 ticks");
        run_ticks(1);
        bus_read(0, 8'h04, 32'h0000_0008, "R4 code 7 at 128 ticks");

        // R5/R6 nonzero start and modulo
        bus_write(0, 8'h4C, 32'h0000_0020, 1'b0);
        bus_write(0, 8'h08, 32'h0000_0022, 1'b0);
        bus_write(0, 8'h00, 32'h0000_0050, 1'b0);
        bus_write(0, 8'h04, 32'h0000_0000, 1'b0);
        run_ticks(2);
        bus_read(0, 8'h04, 32'h0000_0022, "R5 climbs from start");
        expect_irq(1'b0, "R6 no flag before reload");
        run_ticks(1);
        bus_read(0, 8'h04, 32'h0000_0020, "R5 reload to nonzero start");
        expect_irq(1'b1, "R6 flag on nonzero reload");

        // R12 byte-swapped instance
        bus_read(1, 8'h08, 32'hFFFF_0000, "R12 swapped modulo reset");
        bus_write(1, 8'h4C, 32'h0700_0000, 1'b0);
        bus_read(1, 8'h4C, 32'h0700_0000, "R12 swapped start");
        bus_write(1, 8'h04, 32'h0000_0000, 1'b0);
        bus_read(1, 8'h04, 32'h0700_0000, "R12 swapped count load");
        bus_write(1, 8'h00, 32'h1000_0000, 1'b0);
        bus_read(1, 8'h00, 32'h1000_0000, "R12 swapped ctrl");
        run_ticks(1);
        bus_read(1, 8'h04, 32'h0800_0000, "R12 swapped counting");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule